// File: doc/BRIEF.md
# Byte-Port Indirect Register Bridge

This block lets a host with an 8-bit I/O port bus reach a space of 16-bit internal registers through a window of four consecutive port addresses. The host first writes a 16-bit register index one byte at a time. It then reads or writes the selected register's 16-bit value one byte at a time. The window sits at a base port that is a parameter, with a default of 0x260. The two low address bits select one of four byte slots.

The bridge keeps the index in a register and drives it onto the internal bus. On a write, the value's low byte waits in a holding register. A write of the high byte combines the two bytes and issues a single 16-bit write strobe. On a read, a read of the low value byte samples the whole internal word and keeps its high byte. A later read of the high byte therefore returns half of the same word, even if the register has changed in the meantime. Host read data is registered and holds its value between accepted reads.

Top module: `ioport_reg_bridge`

## Requirements
- R1: An access is accepted only while `host_cs` is 1 and `host_addr[15:2]` equals `BASE_PORT[15:2]` (default base 0x260). Any other access changes no state and issues no strobe.
- R2: An accepted write to slot 0 (`host_addr[1:0]`=0) loads `reg_index[7:0]`. An accepted write to slot 1 loads `reg_index[15:8]`. `reg_index` shows the new byte from the cycle after the write strobe, and an index write never raises `reg_we`.
- R3: An accepted read of slot 0 returns `reg_index[7:0]` and a read of slot 1 returns `reg_index[15:8]`, on `host_rdata` in the cycle after the read strobe.
- R4: An accepted write to slot 2 only stores the byte in a holding register. It issues no internal write.
- R5: An accepted write to slot 3 raises `reg_we` for exactly one cycle, in the cycle after the write strobe. In that cycle `reg_wdata` = {written byte, held low byte} at the current `reg_index`.
- R6: An accepted read of slot 2 returns `reg_rdata[7:0]` in the cycle after the strobe and stores `reg_rdata[15:8]` in the same clock edge.
- R7: An accepted read of slot 3 returns the high byte stored by the most recent slot-2 read, whatever `reg_rdata` shows now.
- R8: Reset (`rst`=1, synchronous) clears the index, the holding register, the stored high byte and `host_rdata` to zero, and holds `reg_we` at 0.
- R9: When `host_wr` and `host_rd` are both 1 in an accepted cycle, the write takes effect and the read is dropped (`host_rdata` keeps its value).
- R10: `host_rdata` changes only on an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_cs | input | 1 | Host cycle qualifier |
| host_addr | input | 16 | Host I/O port address |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |
| reg_index | output | 16 | Index of the internal register |
| reg_wdata | output | 16 | Internal write word |
| reg_we | output | 1 | Internal write strobe, one cycle |
| reg_rdata | input | 16 | Internal read word for `reg_index` |

## Verification
Each result is due one clock edge after its host strobe is sampled. Index bytes appear on `reg_index`, read bytes on `host_rdata`, and the commit on `reg_we`/`reg_wdata` all show up one cycle after the strobe. Strobes are driven on the falling edge and held for one cycle, and outputs are sampled on the falling edge after the capturing rising edge. Write strobes are counted by a process on the rising edge, so the strobe count is checked one extra cycle after a slot-3 write. This includes the checks that the count does not change after index, slot-2, out-of-window and deselected writes.

// File: rtl/brg_pkg.sv
package brg_pkg;
  typedef enum logic [1:0] {
    SLOT_IDX_LO = 2'd0,
    SLOT_IDX_HI = 2'd1,
    SLOT_VAL_LO = 2'd2,
    SLOT_VAL_HI = 2'd3
  } slot_e;

  localparam int NUM_SLOTS = 4;

  typedef struct packed {
    logic [NUM_SLOTS-1:0] wr;
    logic [NUM_SLOTS-1:0] rd;
  } slot_strb_t;
endpackage

// File: rtl/brg_decode.sv
module brg_decode
  import brg_pkg::*;
#(
  parameter int PORT_AW = 16,
  parameter logic [PORT_AW-1:0] BASE_PORT = 16'h0260
) (
  input  logic               cs,
  input  logic [PORT_AW-1:0] addr,
  input  logic               wr,
  input  logic               rd,
  output logic               win_hit,
  output slot_strb_t         strb
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int WIN_W  = PORT_AW - SLOT_W;
  localparam logic [WIN_W-1:0] WIN_TAG = BASE_PORT[PORT_AW-1:SLOT_W];

  function automatic logic in_window(input logic [PORT_AW-1:0] a);
    return a[PORT_AW-1:SLOT_W] == WIN_TAG;
  endfunction

  logic [SLOT_W-1:0] slot;
  assign slot    = addr[SLOT_W-1:0];
  assign win_hit = cs && in_window(addr);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign strb.wr[s] = win_hit && wr && (slot == SLOT_W'(s));
    assign strb.rd[s] = win_hit && rd && !wr && (slot == SLOT_W'(s));
  end
endmodule

// File: rtl/brg_index.sv
module brg_index #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic [1:0]        we,
  output logic [2*BYTE_W-1:0] index
);
  for (genvar b = 0; b < 2; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)        index[b*BYTE_W +: BYTE_W] <= '0;
      else if (we[b]) index[b*BYTE_W +: BYTE_W] <= wbyte;
    end
  end

  a_r2_index_hold: assert property (@(posedge clk) disable iff (rst)
    (we == 2'b00) |=> $stable(index));
endmodule

// File: rtl/brg_value.sv
module brg_value #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [BYTE_W-1:0]   wbyte,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic                rd_lo,
  input  logic [2*BYTE_W-1:0] rword,
  output logic [2*BYTE_W-1:0] wword,
  output logic                wstrobe,
  output logic [BYTE_W-1:0]   hi_snap
);
  localparam int WORD_W = 2 * BYTE_W;

  function automatic logic [WORD_W-1:0] join_bytes(input logic [BYTE_W-1:0] hi,
                                                   input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [BYTE_W-1:0] upper_byte(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:BYTE_W];
  endfunction

  logic [BYTE_W-1:0] hold_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_lo <= '0;
      wstrobe <= 1'b0;
      wword   <= '0;
      hi_snap <= '0;
    end else begin
      wstrobe <= wr_hi;
      if (wr_lo) hold_lo <= wbyte;
      if (wr_hi) wword   <= join_bytes(wbyte, hold_lo);
      if (rd_lo) hi_snap <= upper_byte(rword);
    end
  end

  a_r4_no_strobe_low: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !wr_hi) |=> !wstrobe);
  a_r5_hi_byte: assert property (@(posedge clk) disable iff (rst)
    wr_hi |=> wword[WORD_W-1:BYTE_W] == $past(wbyte));
  a_r7_snap_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_lo |=> $stable(hi_snap));
endmodule

// File: rtl/ioport_reg_bridge.sv
module ioport_reg_bridge
  import brg_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int PORT_AW = 16,
  parameter logic [PORT_AW-1:0] BASE_PORT = 16'h0260,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_cs,
  input  logic [PORT_AW-1:0] host_addr,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [BYTE_W-1:0]  host_wdata,
  output logic [BYTE_W-1:0]  host_rdata,
  output logic [WORD_W-1:0]  reg_index,
  output logic [WORD_W-1:0]  reg_wdata,
  output logic               reg_we,
  input  logic [WORD_W-1:0]  reg_rdata
);
  slot_strb_t        strb;
  logic              win_hit;
  logic [BYTE_W-1:0] hi_snap;
  logic              ev_rd_any;
  logic              ev_wr_commit;

  brg_decode #(.PORT_AW(PORT_AW), .BASE_PORT(BASE_PORT)) u_decode (
    .cs(host_cs), .addr(host_addr), .wr(host_wr), .rd(host_rd),
    .win_hit(win_hit), .strb(strb)
  );

  brg_index #(.BYTE_W(BYTE_W)) u_index (
    .clk(clk), .rst(rst), .wbyte(host_wdata),
    .we({strb.wr[SLOT_IDX_HI], strb.wr[SLOT_IDX_LO]}),
    .index(reg_index)
  );

  brg_value #(.BYTE_W(BYTE_W)) u_value (
    .clk(clk), .rst(rst), .wbyte(host_wdata),
    .wr_lo(strb.wr[SLOT_VAL_LO]), .wr_hi(strb.wr[SLOT_VAL_HI]),
    .rd_lo(strb.rd[SLOT_VAL_LO]), .rword(reg_rdata),
    .wword(reg_wdata), .wstrobe(reg_we), .hi_snap(hi_snap)
  );

  assign ev_rd_any    = |strb.rd;
  assign ev_wr_commit = strb.wr[SLOT_VAL_HI];

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else begin
      unique case (1'b1)
        strb.rd[SLOT_IDX_LO]: host_rdata <= reg_index[BYTE_W-1:0];
        strb.rd[SLOT_IDX_HI]: host_rdata <= reg_index[WORD_W-1:BYTE_W];
        strb.rd[SLOT_VAL_LO]: host_rdata <= reg_rdata[BYTE_W-1:0];
        strb.rd[SLOT_VAL_HI]: host_rdata <= hi_snap;
        default: ;
      endcase
    end
  end

  // R1 / R5: every internal write traces back to an in-window slot-3 host write
  a_r5_strobe_cause: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> $past(host_cs && host_wr && host_addr[1:0] == 2'd3 &&
                      host_addr[PORT_AW-1:2] == BASE_PORT[PORT_AW-1:2]));
  a_r1_outside_quiet: assert property (@(posedge clk) disable iff (rst)
    !win_hit |=> $stable(reg_index) && $stable(host_rdata) && !reg_we);
  a_r6_low_byte: assert property (@(posedge clk) disable iff (rst)
    strb.rd[SLOT_VAL_LO] |=> host_rdata == $past(reg_rdata[BYTE_W-1:0]));
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !ev_rd_any |=> $stable(host_rdata));
  a_r8_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (reg_index == '0 && host_rdata == '0 && !reg_we));
  a_r5_single_commit: assert property (@(posedge clk) disable iff (rst)
    !ev_wr_commit |=> !reg_we);
endmodule

// File: tb/ioport_reg_bridge_test.sv
module ioport_reg_bridge_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_cs = 1'b0;
  logic [15:0] host_addr = 16'h0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_wdata = 8'h0;
  logic [7:0]  host_rdata;
  logic [15:0] reg_index;
  logic [15:0] reg_wdata;
  logic        reg_we;
  logic [15:0] reg_rdata;

  logic [15:0] regs [16];
  int unsigned strobes = 0;
  int unsigned checks = 0;
  int unsigned fails = 0;

  always #2 clk = ~clk;

  ioport_reg_bridge uut (
    .clk(clk), .rst(rst), .host_cs(host_cs), .host_addr(host_addr),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .reg_index(reg_index), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = regs[reg_index[3:0]];

  always @(posedge clk) begin
    if (reg_we) begin
      regs[reg_index[3:0]] <= reg_wdata;
      strobes <= strobes + 1;
    end
  end

  localparam logic [15:0] BASE = 16'h0260;

  // Vector: {is_write, slot[1:0], data[7:0], expected_read[7:0]}
  localparam int NV = 20;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 2'd0, 8'h05, 8'h00}, {1'b1, 2'd1, 8'h00, 8'h00},
    {1'b1, 2'd2, 8'h34, 8'h00}, {1'b1, 2'd3, 8'h12, 8'h00},
    {1'b0, 2'd0, 8'h00, 8'h05}, {1'b0, 2'd1, 8'h00, 8'h00},
    {1'b0, 2'd2, 8'h00, 8'h34}, {1'b0, 2'd3, 8'h00, 8'h12},
    {1'b1, 2'd0, 8'h0A, 8'h00}, {1'b1, 2'd2, 8'hCD, 8'h00},
    {1'b1, 2'd3, 8'hAB, 8'h00}, {1'b0, 2'd2, 8'h00, 8'hCD},
    {1'b0, 2'd3, 8'h00, 8'hAB}, {1'b1, 2'd1, 8'h7F, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'h7F}, {1'b0, 2'd2, 8'h00, 8'hCD},
    {1'b1, 2'd0, 8'h05, 8'h00}, {1'b0, 2'd3, 8'h00, 8'hAB},
    {1'b0, 2'd2, 8'h00, 8'h34}, {1'b0, 2'd3, 8'h00, 8'h12}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [15:0] a, input logic [7:0] d, input logic cs = 1'b1);
    @(negedge clk);
    host_cs = cs; host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_cs = 1'b0;
  endtask

  task automatic hread(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    host_cs = 1'b1; host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0; host_cs = 1'b0;
    d = host_rdata;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] rb;
    int unsigned s0;
    for (int i = 0; i < 16; i++) regs[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R8: state after reset
    check("R8 index", reg_index, 16'h0000);
    check("R8 we", {15'h0, reg_we}, 16'h0);
    hread(BASE + 3, rb);
    check("R8 hi snap", {8'h0, rb}, 16'h0000);

    // R2 R3 R5 R6 R7: table walk
    for (int v = 0; v < NV; v++) begin
      logic [18:0] e;
      e = VEC[v];
      if (e[18]) hwrite(BASE + {14'h0, e[17:16]}, e[15:8]);
      else begin
        hread(BASE + {14'h0, e[17:16]}, rb);
        check($sformatf("R3/R6/R7 row %0d", v), {8'h0, rb}, {8'h0, e[7:0]});
      end
    end
    @(negedge clk);
    check("R5 reg5", regs[5], 16'h1234);
    check("R5 regA", regs[10], 16'hABCD);
    check("R5 strobe count", 16'(strobes), 16'd2);
    check("R2 index", reg_index, 16'h7F05);

    // R4: low-byte write alone commits nothing
    hwrite(BASE + 0, 8'h03);
    hwrite(BASE + 1, 8'h00);
    s0 = strobes;
    hwrite(BASE + 2, 8'hEE);
    repeat (2) @(negedge clk);
    check("R4 no strobe", 16'(strobes), 16'(s0));
    check("R4 reg3 untouched", regs[3], 16'h0000);
    hwrite(BASE + 3, 8'h11);
    @(negedge clk);
    check("R5 commit", regs[3], 16'h11EE);
    check("R5 one strobe", 16'(strobes), 16'(s0 + 1));

    // R1: out-of-window and deselected accesses ignored
    s0 = strobes;
    hwrite(16'h0264, 8'h09);
    hwrite(16'h0263 & 16'hFFFC | 16'h0003 | 16'h0400, 8'h55);
    hwrite(BASE + 0, 8'h0C, 1'b0);
    repeat (2) @(negedge clk);
    check("R1 index unchanged", reg_index, 16'h0003);
    check("R1 no strobe", 16'(strobes), 16'(s0));

    // R10: read outside window leaves host_rdata alone
    hread(BASE + 0, rb);
    check("R3 idx lo", {8'h0, rb}, 16'h0003);
    hread(16'h025C, rb);
    check("R10 rdata held", {8'h0, host_rdata}, 16'h0003);

    // R9: simultaneous read and write -> write wins, read dropped
    hread(BASE + 2, rb);
    check("R6 lo", {8'h0, rb}, 16'h00EE);
    @(negedge clk);
    host_cs = 1'b1; host_addr = BASE + 0; host_wdata = 8'h09;
    host_wr = 1'b1; host_rd = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0; host_cs = 1'b0;
    check("R9 rdata kept", {8'h0, host_rdata}, 16'h00EE);
    check("R9 write done", reg_index, 16'h0009);

    // R8: reset mid-run clears index and holding register
    hwrite(BASE + 2, 8'h66);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R8 index clear", reg_index, 16'h0000);
    check("R8 rdata clear", {8'h0, host_rdata}, 16'h0000);
    hwrite(BASE + 3, 8'h77);
    @(negedge clk);
    check("R8 hold clear", regs[0], 16'h7700);

    summary();
  end
endmodule